// File: doc/BRIEF.md
# Buffered SPI Master with Shared Byte Buffer

This block is an SPI master that the host drives through a byte-wide register window. The host places outgoing bytes in a buffer RAM. It then writes a control word that holds a byte count and a set of flags, and the engine clocks that many bytes out in SPI mode 0. The serial link is full duplex. Every byte clocked in is written back over the outgoing byte at the same buffer position, so the reply is read from the buffer once the fragment is done.

A message longer than the buffer is sent as several fragments. Chip select goes active on the first start. It stays active between fragments and is released only when a fragment that carries the final-fragment flag has finished. A separate release write puts chip select back to its idle level before a new message. On completion a status flag is set, and this flag can drive an interrupt line. The SCK rate comes from a programmable divider of the system clock.

Top module: `spi_buf_master`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0 and irq is 0. The control bytes at offsets 1024 and 1025 read 0x00. The divider reads 2 at offset 1026 and 0 at offset 1027.
- R2: Register map, byte-addressed, with read data valid on host_rdata in the cycle after a host_rd request:
  - Offsets 0 to 1023 are the buffer.
  - Offset 1024 holds count bits [7:0].
  - Offset 1025 holds the control and status byte, with bit layout busy/start=7, final=6, irq-enable=5, done=4, count[9:8]=[1:0].
  - Offsets 1026 and 1027 hold the 16-bit divider, low byte first.
- R3: A write to offset 1025 with bit 7 set starts a fragment of count bytes. A count of 0 means 1024 bytes. Bytes go out on spi_mosi MSB first, in buffer order, in mode 0: SCK idles low and spi_mosi changes only while SCK is low.
- R4: The byte received during transfer of buffer byte k is stored at buffer offset k.
- R5: spi_cs_n goes low when a fragment starts. It stays low after a fragment written with bit 6 clear, so the next fragment continues the same message. It goes high when a fragment written with bit 6 set completes.
- R6: A write to offset 1025 with bit 6 set and bit 7 clear, while the engine is idle, drives spi_cs_n high.
- R7: The done flag (bit 4 of offset 1025) is set when a fragment completes. Writing 1 to bit 4 clears it. If the clear write arrives in the same cycle as completion, the set wins.
- R8: irq is a registered copy of done AND irq-enable. Bit 5 of every write to offset 1025 loads the irq-enable flag.
- R9: While a fragment is running, a start write is ignored and buffer writes are ignored.
- R10: SCK is high for exactly D system clocks per bit, where D is the divider value; a value of 0 acts as 1. SCK stays low whenever the engine is idle.
- R11: Bit 7 of offset 1025 reads 1 while a fragment is running and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read request |
| host_addr | input | 11 | Host byte offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid one cycle after host_rd |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Completion interrupt |

## Verification
Two events can land in the same clock edge: a fragment completing and setting the done flag, and a host write that clears the same flag. The bench provokes this by holding a clear write on the control byte on every cycle of a running fragment, with irq-enable kept at 1. The collision is judged at irq. The set must win, so irq must be seen high for at least one cycle. If the clear had priority, irq would never rise.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
  typedef enum logic [2:0] {
    E_IDLE,
    E_FETCH,
    E_LOAD,
    E_LOW,
    E_HIGH,
    E_STORE
  } eng_state_t;

  // bit positions inside the control/status high byte
  localparam int unsigned CB_START = 7;
  localparam int unsigned CB_FINAL = 6;
  localparam int unsigned CB_IE    = 5;
  localparam int unsigned CB_DONE  = 4;
endpackage

// File: rtl/spi_buf_ram.sv
module spi_buf_ram #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [7:0]    b_wdata,
  output logic [7:0]    b_rdata
);
  logic [7:0] mem [DEPTH];

  // single write port, engine first; host writes are gated off while busy
  always_ff @(posedge clk) begin
    if (b_we) begin
      mem[b_addr] <= b_wdata;
    end else if (a_we) begin
      mem[a_addr] <= a_wdata;
    end
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] lim_m1;

  always_comb begin
    lim_m1 = (div == '0) ? '0 : div - DW'(1);
    tick   = en && (cnt_q == lim_m1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DW'(1);
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_buf_pkg::*;
#(
  parameter int unsigned AW = 10,
  localparam int unsigned LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [LW-1:0] len,
  input  logic          tick,
  input  logic          miso,
  input  logic [7:0]    rdata,
  output logic [AW-1:0] addr,
  output logic          we,
  output logic [7:0]    wdata,
  output logic          tick_en,
  output logic          busy,
  output logic          done,
  output logic          sck,
  output logic          mosi
);
  eng_state_t    st_q;
  logic [LW-1:0] idx_q, len_q;
  logic [7:0]    sh_q;
  logic [2:0]    bit_q;
  logic          sck_q, mosi_q;
  logic          last_byte;

  always_comb begin
    last_byte = (idx_q + LW'(1)) == len_q;
    addr      = idx_q[AW-1:0];
    we        = (st_q == E_STORE);
    wdata     = sh_q;
    done      = (st_q == E_STORE) && last_byte;
    busy      = (st_q != E_IDLE);
    tick_en   = (st_q == E_LOW) || (st_q == E_HIGH);
    sck       = sck_q;
    mosi      = mosi_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= E_IDLE;
      idx_q  <= '0;
      len_q  <= '0;
      sh_q   <= '0;
      bit_q  <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
    end else begin
      case (st_q)
        E_IDLE: if (start) begin
          len_q <= len;
          idx_q <= '0;
          st_q  <= E_FETCH;
        end
        E_FETCH: st_q <= E_LOAD;
        E_LOAD: begin
          sh_q   <= rdata;
          mosi_q <= rdata[7];
          bit_q  <= '0;
          st_q   <= E_LOW;
        end
        E_LOW: if (tick) begin
          sck_q <= 1'b1;
          sh_q  <= {sh_q[6:0], miso};
          st_q  <= E_HIGH;
        end
        E_HIGH: if (tick) begin
          sck_q <= 1'b0;
          if (bit_q == 3'd7) begin
            st_q <= E_STORE;
          end else begin
            bit_q  <= bit_q + 3'd1;
            mosi_q <= sh_q[7];
            st_q   <= E_LOW;
          end
        end
        E_STORE: begin
          idx_q <= idx_q + LW'(1);
          st_q  <= last_byte ? E_IDLE : E_FETCH;
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master
  import spi_buf_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 1024,   // 512..4096
  parameter logic [15:0] DIV_RESET = 16'd2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         host_wr,
  input  logic                         host_rd,
  input  logic [$clog2(BUF_BYTES):0]   host_addr,
  input  logic [7:0]                   host_wdata,
  output logic [7:0]                   host_rdata,
  output logic                         spi_sck,
  output logic                         spi_cs_n,
  output logic                         spi_mosi,
  input  logic                         spi_miso,
  output logic                         irq
);
  localparam int unsigned AW = $clog2(BUF_BYTES);
  localparam int unsigned LW = AW + 1;
  localparam int unsigned HW = AW + 1;
  localparam logic [HW-1:0] A_CTL_LO = HW'(BUF_BYTES);
  localparam logic [HW-1:0] A_CTL_HI = HW'(BUF_BYTES + 1);
  localparam logic [HW-1:0] A_DIV_LO = HW'(BUF_BYTES + 2);
  localparam logic [HW-1:0] A_DIV_HI = HW'(BUF_BYTES + 3);
  localparam logic [3:0]    HI_MASK  = 4'((1 << (AW - 8)) - 1);

  logic          eng_busy, eng_done, eng_we, eng_tick, eng_tick_en;
  logic [AW-1:0] eng_addr;
  logic [7:0]    eng_wdata, eng_rdata, host_ram_q;

  logic          cs_n_q, last_q, ie_q, done_q, irq_q, rd_buf_q;
  logic [7:0]    cnt_lo_q, reg_q;
  logic [3:0]    cnt_hi_q;
  logic [15:0]   div_q;

  logic          buf_sel, buf_we, ctl_hi_wr, start_ok, release_cs;
  logic          done_n, ie_n;
  logic [AW-1:0] cnt_now;
  logic [LW-1:0] start_len;

  always_comb begin
    buf_sel    = host_addr < HW'(BUF_BYTES);
    buf_we     = host_wr && buf_sel && !eng_busy;
    ctl_hi_wr  = host_wr && (host_addr == A_CTL_HI);
    start_ok   = ctl_hi_wr && host_wdata[CB_START] && !eng_busy;
    release_cs = ctl_hi_wr && !host_wdata[CB_START] && host_wdata[CB_FINAL] && !eng_busy;
    cnt_now    = AW'({host_wdata[3:0] & HI_MASK, cnt_lo_q});
    start_len  = (cnt_now == '0) ? LW'(BUF_BYTES) : {1'b0, cnt_now};
    // completion beats a simultaneous clear
    if (eng_done) begin
      done_n = 1'b1;
    end else if (ctl_hi_wr && host_wdata[CB_DONE]) begin
      done_n = 1'b0;
    end else begin
      done_n = done_q;
    end
    ie_n = ctl_hi_wr ? host_wdata[CB_IE] : ie_q;
  end

  spi_buf_ram #(.DEPTH(BUF_BYTES)) u_ram (
    .clk     (clk),
    .a_addr  (host_addr[AW-1:0]),
    .a_we    (buf_we),
    .a_wdata (host_wdata),
    .a_rdata (host_ram_q),
    .b_addr  (eng_addr),
    .b_we    (eng_we),
    .b_wdata (eng_wdata),
    .b_rdata (eng_rdata)
  );

  spi_sck_div #(.DW(16)) u_div (
    .clk  (clk),
    .rst  (rst),
    .en   (eng_tick_en),
    .div  (div_q),
    .tick (eng_tick)
  );

  spi_shift_engine #(.AW(AW)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .start   (start_ok),
    .len     (start_len),
    .tick    (eng_tick),
    .miso    (spi_miso),
    .rdata   (eng_rdata),
    .addr    (eng_addr),
    .we      (eng_we),
    .wdata   (eng_wdata),
    .tick_en (eng_tick_en),
    .busy    (eng_busy),
    .done    (eng_done),
    .sck     (spi_sck),
    .mosi    (spi_mosi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_q   <= 1'b1;
      last_q   <= 1'b0;
      ie_q     <= 1'b0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
      cnt_lo_q <= '0;
      cnt_hi_q <= '0;
      div_q    <= DIV_RESET;
      rd_buf_q <= 1'b0;
      reg_q    <= '0;
    end else begin
      done_q <= done_n;
      ie_q   <= ie_n;
      irq_q  <= done_n && ie_n;
      if (host_wr && (host_addr == A_CTL_LO)) cnt_lo_q <= host_wdata;
      if (ctl_hi_wr && !eng_busy) begin
        cnt_hi_q <= host_wdata[3:0] & HI_MASK;
        last_q   <= host_wdata[CB_FINAL];
      end
      if (host_wr && (host_addr == A_DIV_LO)) div_q[7:0]  <= host_wdata;
      if (host_wr && (host_addr == A_DIV_HI)) div_q[15:8] <= host_wdata;
      if (start_ok) begin
        cs_n_q <= 1'b0;
      end else if ((eng_done && last_q) || release_cs) begin
        cs_n_q <= 1'b1;
      end
      if (host_rd) begin
        rd_buf_q <= buf_sel;
        case (host_addr)
          A_CTL_LO: reg_q <= cnt_lo_q;
          A_CTL_HI: reg_q <= {eng_busy, last_q, ie_q, done_q, cnt_hi_q};
          A_DIV_LO: reg_q <= div_q[7:0];
          A_DIV_HI: reg_q <= div_q[15:8];
          default:  reg_q <= '0;
        endcase
      end
    end
  end

  assign host_rdata = rd_buf_q ? host_ram_q : reg_q;
  assign spi_cs_n   = cs_n_q;
  assign irq        = irq_q;
endmodule

// File: rtl/spi_buf_master_chk.sv
module spi_buf_master_chk (
  input logic clk,
  input logic rst,
  input logic spi_sck,
  input logic spi_cs_n,
  input logic spi_mosi,
  input logic irq,
  input logic busy,
  input logic done,
  input logic ie
);
  p_sck_low_when_deselected_r10: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);

  p_sck_low_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !spi_sck);

  p_cs_held_while_busy_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> !spi_cs_n);

  p_mosi_steady_high_sck_r3: assert property (@(posedge clk) disable iff (rst)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  p_irq_needs_flags_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (done && ie));
endmodule

bind spi_buf_master spi_buf_master_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .spi_sck  (spi_sck),
  .spi_cs_n (spi_cs_n),
  .spi_mosi (spi_mosi),
  .irq      (irq),
  .busy     (eng_busy),
  .done     (done_q),
  .ie       (ie_q)
);

// File: tb/sim_spi_buf_master.sv
`timescale 1ns/1ps
module sim_spi_buf_master;
  logic        clk = 1'b0;
  logic        rst;
  logic        host_wr, host_rd;
  logic [10:0] host_addr;
  logic [7:0]  host_wdata, host_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_miso, irq;

  always #10 clk = ~clk;

  spi_buf_master u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rep(input int k);
    return 8'(k * 29 + 91);
  endfunction

  // slave model: reply byte k of the message, index restarts on deselect
  int sl_idx = 0;
  int sl_bit = 0;
  logic [7:0] sl_byte;
  always_comb sl_byte = rep(sl_idx);
  assign spi_miso = sl_byte[3'(7 - sl_bit)];

  // scoreboard
  logic [7:0] exp_q[$];
  logic [7:0] mon_sh = '0;
  int mon_bits = 0;
  int n_bytes = 0;

  always @(posedge spi_cs_n) begin
    sl_idx = 0;
    sl_bit = 0;
    mon_bits = 0;
  end

  always @(posedge spi_sck) begin
    logic [7:0] got;
    got = {mon_sh[6:0], spi_mosi};
    mon_sh = got;
    mon_bits++;
    if (mon_bits == 8) begin
      mon_bits = 0;
      n_bytes++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected byte", got, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(got == e, "R3 mosi byte", got, e);
      end
    end
    sl_bit++;
    if (sl_bit == 8) begin
      sl_bit = 0;
      sl_idx++;
    end
  end

  // SCK high-width monitor
  int hi_run = 0;
  int last_hi = 0;
  always @(negedge clk) begin
    if (spi_sck) hi_run++;
    else if (hi_run != 0) begin
      last_hi = hi_run;
      hi_run = 0;
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 11'(a); host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = 11'(a);
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  // driver: load buffer and queue the expected serial bytes
  task automatic load_byte(input int a, input logic [7:0] d);
    wr(a, d);
    exp_q.push_back(d);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int n = 0;
    do begin
      rd(1025, s);
      n++;
    end while (s[7] && n < 60000);
    check(!s[7], "R11 busy clears", s, 0);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int nb0;
    bit seen;
    rst = 1'b1; host_wr = 1'b0; host_rd = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
    check(spi_sck == 1'b0, "R1 sck", spi_sck, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    rd(1024, d); check(d == 8'h00, "R1 count", d, 0);
    rd(1025, d); check(d == 8'h00, "R1 status", d, 0);
    rd(1026, d); check(d == 8'h02, "R1 div lo", d, 2);
    rd(1027, d); check(d == 8'h00, "R1 div hi", d, 0);

    // R2 buffer readback
    wr(10, 8'h77); wr(1023, 8'hC4);
    rd(10, d);   check(d == 8'h77, "R2 buf 10", d, 8'h77);
    rd(1023, d); check(d == 8'hC4, "R2 buf 1023", d, 8'hC4);

    // first fragment of a message: 3 bytes, irq enabled, not final
    load_byte(0, 8'h11); load_byte(1, 8'h22); load_byte(2, 8'h33);
    nb0 = n_bytes;
    wr(1024, 3);
    wr(1025, 8'hA0);
    check(spi_cs_n == 1'b0, "R5 cs asserts", spi_cs_n, 0);
    rd(1025, d); check(d[7] == 1'b1, "R11 busy set", d, 8'h80);
    wr(10, 8'hEE);          // R9: ignored while busy
    wr(1025, 8'hA0);        // R9: start ignored while busy
    wait_idle();
    check(n_bytes - nb0 == 3, "R9 byte count", n_bytes - nb0, 3);
    check(irq == 1'b1, "R8 irq on done", irq, 1);
    check(spi_cs_n == 1'b0, "R5 cs held", spi_cs_n, 0);
    for (int k = 0; k < 3; k++) begin
      rd(k, d); check(d == rep(k), "R4 reply", d, rep(k));
    end
    rd(10, d); check(d == 8'h77, "R9 buf write ignored", d, 8'h77);
    rd(1025, d); check(d == 8'h30, "R7 status done", d, 8'h30);
    wr(1025, 8'h10);
    check(irq == 1'b0, "R8 irq cleared", irq, 0);
    rd(1025, d); check(d == 8'h00, "R7 done cleared", d, 0);

    // final fragment of the same message, irq disabled
    load_byte(0, 8'h5A); load_byte(1, 8'hC3);
    wr(1024, 2);
    wr(1025, 8'hC0);
    wait_idle();
    check(spi_cs_n == 1'b1, "R5 cs released", spi_cs_n, 1);
    rd(0, d); check(d == rep(3), "R5 continued message", d, rep(3));
    rd(1, d); check(d == rep(4), "R4 reply", d, rep(4));
    check(irq == 1'b0, "R8 irq masked", irq, 0);
    rd(1025, d); check(d == 8'h50, "R7 status final", d, 8'h50);
    wr(1025, 8'h20);
    check(irq == 1'b1, "R8 irq on enable", irq, 1);
    wr(1025, 8'h10);
    check(irq == 1'b0, "R8 irq off", irq, 0);

    // R6 release write
    load_byte(0, 8'h81);
    wr(1024, 1);
    wr(1025, 8'h80);
    wait_idle();
    check(spi_cs_n == 1'b0, "R5 cs held open", spi_cs_n, 0);
    wr(1025, 8'h10);
    wr(1025, 8'h40);
    check(spi_cs_n == 1'b1, "R6 release", spi_cs_n, 1);
    wr(1025, 8'h00);
    load_byte(0, 8'h42);
    wr(1025, 8'hC0);
    wait_idle();
    rd(0, d); check(d == rep(0), "R6 new message", d, rep(0));
    wr(1025, 8'h10);

    // R10 divider 3
    wr(1026, 3);
    rd(1026, d); check(d == 8'h03, "R2 div write", d, 3);
    load_byte(0, 8'hF0);
    wr(1024, 1);
    wr(1025, 8'hC0);
    wait_idle();
    check(last_hi == 3, "R10 sck high width", last_hi, 3);
    wr(1025, 8'h10);

    // R3 count 0 = full buffer, divider 0 acts as 1
    wr(1026, 0);
    for (int k = 0; k < 1024; k++) load_byte(k, 8'(k ^ 8'h3C));
    nb0 = n_bytes;
    wr(1024, 0);
    wr(1025, 8'hC0);
    wait_idle();
    check(n_bytes - nb0 == 1024, "R3 full fragment", n_bytes - nb0, 1024);
    check(last_hi == 1, "R10 div zero", last_hi, 1);
    rd(0, d);    check(d == rep(0), "R4 reply first", d, rep(0));
    rd(1023, d); check(d == rep(1023), "R4 reply last", d, rep(1023));
    wr(1025, 8'h10);

    // R7 collision: clear write held every cycle across completion
    load_byte(0, 8'h99);
    wr(1024, 1);
    wr(1025, 8'hE0);
    seen = 0;
    @(negedge clk);
    host_wr = 1'b1; host_addr = 11'd1025; host_wdata = 8'h30;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (irq) begin
        seen = 1;
        break;
      end
    end
    @(negedge clk);
    host_wr = 1'b0;
    check(seen, "R7 set wins over clear", seen, 1);
    @(negedge clk);
    check(irq == 1'b0, "R7 later clear", irq, 0);
    rd(1025, d); check(d[4] == 1'b0, "R7 done bit", d, 8'h20);

    check(exp_q.size() == 0, "R3 all bytes sent", exp_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule